// File: doc/BRIEF.md
# Trimmed Real-Time Counter with Subsecond Match

This block keeps time from a 32.768 kHz oscillator. A strobe on `tick_i` (one clock cycle per oscillator period) advances a 15-bit subsecond count; each wrap of that count advances a 32-bit seconds count. Software can correct a fast or slow oscillator through a 16-bit trim value. The trim does not retune a divider. Once per trim period, the wrap from one second to the next reloads the subsecond count with a trim-derived value. The count then either replays part of the range, which lengthens the second, or skips part of it, which shortens the second. The trim period is 64 seconds in counter mode and 60 seconds in calendar mode.

A compare unit raises a one-cycle pulse when an advance brings both counts onto the programmed match pair. The pulse also sets a sticky flag that software clears by writing a one. Because of the replay and skip, a subsecond match value near the wrap can fire twice in the trimmed second, or not at all. A single write port loads the counters, the trim value and the match pair.

Top module: `rtc_trim_match`

## Requirements
- R1: After reset, seconds and subseconds read 0, `match_o` and `irq_o` are low, the trim value is 0x7FFF and the match pair is (0, 0).
- R2: An advance raises subseconds by one. From 0x7FFF, an untrimmed advance wraps subseconds to 0 and raises seconds by one.
- R3: With trim T above 0x7FFF, the trimmed wrap raises seconds and loads subseconds with 0xFFFF − T. The count then climbs to 0x7FFF and wraps to 0 once without a seconds increment. The new second therefore lasts T + 1 advances.
- R4: With trim T below 0x7FFF, the trimmed wrap raises seconds and loads subseconds with 0x7FFF − T, skipping the lower values. The new second lasts T + 1 advances.
- R5: With `cal_mode_i` low, a wrap is trimmed only when the seconds value before the increment is a multiple of 64.
- R6: With `cal_mode_i` high, a wrap is trimmed only when the seconds value before the increment is a multiple of 60.
- R7: At the nominal trim of 0x7FFF, a trimmed wrap behaves exactly like an untrimmed one.
- R8: A match pair inside the replayed range of a slowed second produces two pulses, for example seconds 1 and subseconds 0x7FFD with trim 0x8003.
- R9: A match pair inside the skipped range of a sped-up second produces no pulse, for example seconds 1 and subseconds 0x2 with trim 0x7F00.
- R10: `match_o` is high for exactly the cycle in which the counters first show the match pair after an advance. `irq_o` is set one cycle later. Writing 1 to bit 0 at address 5 clears `irq_o`, and a set in the same cycle as a clear wins.
- R11: An advance happens on a clock edge only when `tick_i` and `run_i` are both high. Otherwise both counters hold.
- R12: Writes use these addresses: 0 loads seconds and clears subseconds and the replay state; 1 loads subseconds; 2 loads trim (bits 15:0); 3 loads match seconds; 4 loads match subseconds (bits 14:0); 5 is the flag clear. A counter write in the same cycle as a tick takes priority, and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per oscillator period |
| run_i | input | 1 | Counting enable |
| cal_mode_i | input | 1 | Selects the 60-second trim period |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| secs_o | output | 32 | Seconds count |
| subsec_o | output | 15 | Subsecond count |
| match_o | output | 1 | Match pulse |
| irq_o | output | 1 | Sticky match flag |

## Verification
Several properties are checked on every cycle. The seconds value either holds or steps by one unless it is written. The counters freeze while counting is disabled, and a seconds write lands with the subseconds cleared. Every match pulse coincides with the programmed pair, and the flag follows the set-over-clear rule. Some behaviours depend on long tick sequences at chosen seconds values: the length of a trimmed second, the 64-versus-60 slot selection, the double pulse in a replayed range and the silence in a skipped one. Only the bench scenarios can show these, and they are compared against a behavioural model on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SEC  = 3'd0,
    ADDR_SUB  = 3'd1,
    ADDR_TRIM = 3'd2,
    ADDR_MSEC = 3'd3,
    ADDR_MSUB = 3'd4,
    ADDR_IRQ  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned SUB_W  = 15,
  parameter int unsigned TRIM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic [SEC_W-1:0]  msec_o,
  output logic [SUB_W-1:0]  msub_o,
  output logic              sec_wr_o,
  output logic              sub_wr_o,
  output logic              irq_clr_o
);
  localparam logic [TRIM_W-1:0] TRIM_NOM = TRIM_W'((1 << SUB_W) - 1);

  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr_i);

  assign sec_wr_o  = wr_en_i && (addr == ADDR_SEC);
  assign sub_wr_o  = wr_en_i && (addr == ADDR_SUB);
  assign irq_clr_o = wr_en_i && (addr == ADDR_IRQ) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_o <= TRIM_NOM;
      msec_o <= '0;
      msub_o <= '0;
    end else if (wr_en_i) begin
      case (addr)
        ADDR_TRIM: trim_o <= wr_data_i[TRIM_W-1:0];
        ADDR_MSEC: msec_o <= wr_data_i;
        ADDR_MSUB: msub_o <= wr_data_i[SUB_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_trim_ctl.sv
module rtc_trim_ctl #(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SUB_W      = 15,
  parameter int unsigned TRIM_W     = 16,
  parameter int unsigned CNT_PERIOD = 64,
  parameter int unsigned CAL_PERIOD = 60
) (
  input  logic [SEC_W-1:0]  secs_i,
  input  logic              cal_mode_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              slot_o,
  output logic [SUB_W-1:0]  load_o,
  output logic              replay_o
);
  logic cnt_zero, cal_zero;

  // power-of-two periods reduce to a bit test
  if ((CNT_PERIOD & (CNT_PERIOD - 1)) == 0) begin : g_cnt_pow2
    assign cnt_zero = (secs_i[$clog2(CNT_PERIOD)-1:0] == '0);
  end else begin : g_cnt_mod
    assign cnt_zero = ((secs_i % SEC_W'(CNT_PERIOD)) == '0);
  end

  if ((CAL_PERIOD & (CAL_PERIOD - 1)) == 0) begin : g_cal_pow2
    assign cal_zero = (secs_i[$clog2(CAL_PERIOD)-1:0] == '0);
  end else begin : g_cal_mod
    assign cal_zero = ((secs_i % SEC_W'(CAL_PERIOD)) == '0);
  end

  assign slot_o   = cal_mode_i ? cal_zero : cnt_zero;
  // 0xFFFF-T above nominal, 0x7FFF-T below: both equal ~T over the low bits
  assign load_o   = ~trim_i[SUB_W-1:0];
  assign replay_o = trim_i[TRIM_W-1];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             sec_wr_i,
  input  logic             sub_wr_i,
  input  logic [SEC_W-1:0] wr_data_i,
  input  logic             slot_i,
  input  logic [SUB_W-1:0] load_i,
  input  logic             replay_i,
  output logic [SEC_W-1:0] secs_o,
  output logic [SUB_W-1:0] subsec_o,
  output logic [SEC_W-1:0] secs_nx_o,
  output logic [SUB_W-1:0] subsec_nx_o,
  output logic             adv_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = '1;

  logic [SEC_W-1:0] sec_q, sec_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             rep_q, rep_d;

  always_comb begin
    sec_d = sec_q;
    sub_d = sub_q;
    rep_d = rep_q;
    adv_o = 1'b0;
    if (sec_wr_i) begin
      sec_d = wr_data_i;
      sub_d = '0;
      rep_d = 1'b0;
    end else if (sub_wr_i) begin
      sub_d = wr_data_i[SUB_W-1:0];
    end else if (step_i) begin
      adv_o = 1'b1;
      if (sub_q != SUB_MAX) begin
        sub_d = sub_q + SUB_W'(1);
      end else if (rep_q) begin
        sub_d = '0;              // end of replay: wrap without a second
        rep_d = 1'b0;
      end else if (slot_i) begin
        sec_d = sec_q + SEC_W'(1);
        sub_d = load_i;
        rep_d = replay_i;
      end else begin
        sec_d = sec_q + SEC_W'(1);
        sub_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      sub_q <= '0;
      rep_q <= 1'b0;
    end else begin
      sec_q <= sec_d;
      sub_q <= sub_d;
      rep_q <= rep_d;
    end
  end

  assign secs_o      = sec_q;
  assign subsec_o    = sub_q;
  assign secs_nx_o   = sec_d;
  assign subsec_nx_o = sub_d;
endmodule

// File: rtl/rtc_match.sv
module rtc_match #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [SEC_W-1:0] secs_nx_i,
  input  logic [SUB_W-1:0] subsec_nx_i,
  input  logic [SEC_W-1:0] msec_i,
  input  logic [SUB_W-1:0] msub_i,
  input  logic             irq_clr_i,
  output logic             match_o,
  output logic             irq_o
);
  logic hit;
  assign hit = adv_i && (secs_nx_i == msec_i) && (subsec_nx_i == msub_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      match_o <= hit;
      if (match_o)        irq_o <= 1'b1;   // set wins over clear
      else if (irq_clr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_trim_match.sv
module rtc_trim_match
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned SUB_W      = 15,
  parameter int unsigned CNT_PERIOD = 64,
  parameter int unsigned CAL_PERIOD = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              cal_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  output logic [SEC_W-1:0]  secs_o,
  output logic [SUB_W-1:0]  subsec_o,
  output logic              match_o,
  output logic              irq_o
);
  localparam int unsigned TRIM_W = SUB_W + 1;

  logic [TRIM_W-1:0] trim_w;
  logic [SEC_W-1:0]  msec_w, secs_nx_w;
  logic [SUB_W-1:0]  msub_w, subsec_nx_w, load_w;
  logic sec_wr_w, sub_wr_w, irq_clr_w, slot_w, replay_w, adv_w;

  rtc_regs #(.SEC_W(SEC_W), .SUB_W(SUB_W), .TRIM_W(TRIM_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .trim_o(trim_w), .msec_o(msec_w), .msub_o(msub_w),
    .sec_wr_o(sec_wr_w), .sub_wr_o(sub_wr_w), .irq_clr_o(irq_clr_w)
  );

  rtc_trim_ctl #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .TRIM_W(TRIM_W),
    .CNT_PERIOD(CNT_PERIOD), .CAL_PERIOD(CAL_PERIOD)
  ) i_trim (
    .secs_i(secs_o), .cal_mode_i, .trim_i(trim_w),
    .slot_o(slot_w), .load_o(load_w), .replay_o(replay_w)
  );

  rtc_counter #(.SEC_W(SEC_W), .SUB_W(SUB_W)) i_cnt (
    .clk_i, .rst_ni, .step_i(tick_i && run_i),
    .sec_wr_i(sec_wr_w), .sub_wr_i(sub_wr_w), .wr_data_i,
    .slot_i(slot_w), .load_i(load_w), .replay_i(replay_w),
    .secs_o, .subsec_o, .secs_nx_o(secs_nx_w), .subsec_nx_o(subsec_nx_w),
    .adv_o(adv_w)
  );

  rtc_match #(.SEC_W(SEC_W), .SUB_W(SUB_W)) i_match (
    .clk_i, .rst_ni, .adv_i(adv_w),
    .secs_nx_i(secs_nx_w), .subsec_nx_i(subsec_nx_w),
    .msec_i(msec_w), .msub_i(msub_w), .irq_clr_i(irq_clr_w),
    .match_o, .irq_o
  );
endmodule

// File: rtl/rtc_trim_match_chk.sv
module rtc_trim_match_chk
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              run_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [SEC_W-1:0]  wr_data_i,
  input logic [SEC_W-1:0]  secs_o,
  input logic [SUB_W-1:0]  subsec_o,
  input logic              match_o,
  input logic              irq_o,
  input logic [SEC_W-1:0]  msec_i,
  input logic [SUB_W-1:0]  msub_i
);
  logic sec_wr, irq_clr;
  assign sec_wr  = wr_en_i && (wr_addr_i == ADDR_SEC);
  assign irq_clr = wr_en_i && (wr_addr_i == ADDR_IRQ) && wr_data_i[0];

  p_sec_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_wr |=> (secs_o == $past(secs_o)) || (secs_o == $past(secs_o) + SEC_W'(1)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(tick_i && run_i)) |=> ($stable(secs_o) && $stable(subsec_o)));

  p_sec_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr |=> (secs_o == $past(wr_data_i)) && (subsec_o == '0));

  p_match_vals_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (secs_o == $past(msec_i)) && (subsec_o == $past(msub_i)));

  p_irq_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> irq_o);

  p_irq_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr && !match_o) |=> !irq_o);
endmodule

bind rtc_trim_match rtc_trim_match_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .run_i(run_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .secs_o(secs_o), .subsec_o(subsec_o), .match_o(match_o), .irq_o(irq_o),
  .msec_i(msec_w), .msub_i(msub_w)
);

// File: tb/test_rtc_trim_match.sv
`timescale 1ns/1ps
module test_rtc_trim_match;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, run = 1'b1, cal = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] secs;
  logic [14:0] subsec;
  logic        match, irq;

  int checks = 0, fails = 0, match_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_trim_match i_rtc_trim_match (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .cal_mode_i(cal),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .secs_o(secs), .subsec_o(subsec), .match_o(match), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_sec, m_msec;
  logic [14:0] m_sub, m_msub;
  logic [15:0] m_trim;
  bit m_rep, m_match, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_sub = 0; m_rep = 0; m_trim = 16'h7fff;
      m_msec = 0; m_msub = 0; m_match = 0; m_irq = 0;
    end else begin
      bit hit;
      int unsigned per;
      hit = 0;
      if (m_match) m_irq = 1;
      else if (wr_en && wr_addr == 5 && wr_data[0]) m_irq = 0;
      if (wr_en && wr_addr == 0) begin
        m_sec = wr_data; m_sub = 0; m_rep = 0;
      end else if (wr_en && wr_addr == 1) begin
        m_sub = wr_data[14:0];
      end else if (tick && run) begin
        if (m_sub < 15'h7fff) m_sub = m_sub + 1;
        else if (m_rep) begin m_sub = 0; m_rep = 0; end
        else begin
          per = cal ? 60 : 64;
          if (m_sec % per == 0) begin
            if (m_trim > 16'h7fff) begin m_sub = 15'(17'hffff - m_trim); m_rep = 1; end
            else m_sub = 15'(16'h7fff - m_trim);
          end else m_sub = 0;
          m_sec = m_sec + 1;
        end
        hit = (m_sec == m_msec) && (m_sub == m_msub);
      end
      if (wr_en && wr_addr == 2) m_trim = wr_data[15:0];
      if (wr_en && wr_addr == 3) m_msec = wr_data;
      if (wr_en && wr_addr == 4) m_msub = wr_data[14:0];
      m_match = hit;
    end
  end

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // cycle compare against the model (R2 and the rest of the counting rules)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 cycle model", {secs, subsec, match, irq}, {m_sec, m_sub, m_match, m_irq});
      if (match) match_cnt++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL R11 watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {secs, subsec, match, irq}, 64'h0);
    rst_n = 1;

    // R7: nominal trim at a trim slot
    wr(1, 32'h7fff); run_ticks(1);
    chk("R7 nominal slot", {secs, subsec}, {32'd1, 15'd0});

    // R2: plain wrap
    wr(0, 5); wr(1, 32'h7ffe); run_ticks(1);
    chk("R2 pre-wrap", {secs, subsec}, {32'd5, 15'h7fff});
    run_ticks(1);
    chk("R2 wrap", {secs, subsec}, {32'd6, 15'd0});

    // R12: writes
    wr(1, 32'h1234);
    chk("R12 sub write", subsec, 15'h1234);
    wr(0, 9);
    chk("R12 sec write clears sub", {secs, subsec}, {32'd9, 15'd0});
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 32'h0040; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    chk("R12 write beats tick", subsec, 15'h0040);

    // R11: hold
    run = 0; run_ticks(20);
    chk("R11 run low holds", {secs, subsec}, {32'd9, 15'h0040});
    run = 1; repeat (5) @(negedge clk);
    chk("R11 tick low holds", {secs, subsec}, {32'd9, 15'h0040});

    // R3/R8: slow trim, replayed match
    wr(2, 32'h8003); wr(3, 1); wr(4, 32'h7ffd); wr(0, 0); wr(1, 32'h7ff0);
    match_cnt = 0;
    run_ticks(16);
    chk("R3 trimmed load", {secs, subsec}, {32'd1, 15'h7ffc});
    run_ticks(32771);
    chk("R3 last tick of long second", {secs, subsec}, {32'd1, 15'h7fff});
    run_ticks(1);
    chk("R3 second length T+1", {secs, subsec}, {32'd2, 15'd0});
    chk("R8 double match", match_cnt, 2);
    chk("R10 flag set", irq, 1);
    wr(5, 1);
    chk("R10 flag cleared", irq, 0);

    // R10: pulse width and set-over-clear
    wr(0, 20); wr(3, 20); wr(4, 1);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk("R10 pulse on entry", match, 1);
    wr_en = 1; wr_addr = 5; wr_data = 1;
    @(negedge clk); wr_en = 0;
    chk("R10 single cycle", match, 0);
    chk("R10 set beats clear", irq, 1);
    wr(5, 1);
    chk("R10 clear", irq, 0);

    // R4/R9: fast trim, skipped match
    wr(2, 32'h7f00); wr(3, 1); wr(4, 2); wr(0, 0); wr(1, 32'h7ff0);
    match_cnt = 0;
    run_ticks(16);
    chk("R4 trimmed load", {secs, subsec}, {32'd1, 15'h00ff});
    run_ticks(32'h7f00);
    chk("R4 last tick of short second", {secs, subsec}, {32'd1, 15'h7fff});
    run_ticks(1);
    chk("R4 second length T+1", {secs, subsec}, {32'd2, 15'd0});
    chk("R9 missed match", match_cnt, 0);
    chk("R9 no flag", irq, 0);

    // R5: counter mode slots
    wr(0, 60); wr(1, 32'h7fff); run_ticks(1);
    chk("R5 sec 60 untrimmed", {secs, subsec}, {32'd61, 15'd0});
    wr(0, 64); wr(1, 32'h7fff); run_ticks(1);
    chk("R5 sec 64 trimmed", {secs, subsec}, {32'd65, 15'h00ff});

    // R6: calendar mode slots
    cal = 1;
    wr(0, 60); wr(1, 32'h7fff); run_ticks(1);
    chk("R6 sec 60 trimmed", {secs, subsec}, {32'd61, 15'h00ff});
    wr(0, 64); wr(1, 32'h7fff); run_ticks(1);
    chk("R6 sec 64 untrimmed", {secs, subsec}, {32'd65, 15'd0});

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule